// File: doc/BRIEF.md
# Reference Clock Loss Supervisor

This block watches a master reference clock from a separate, faster, free-running monitor clock. The reference clock passes through a synchroniser into the monitor domain. Over each reference period, measured from one rising edge to the next, the block counts the monitor cycles in which the reference is high and the cycles in which it is low. It then judges the period good or bad. A period is bad when either phase is shorter than a set share of the whole period. It is also bad when no rising edge arrives within the longest expected period.

If no good period arrives for a persistence window after a bad one, the block declares the reference lost and forces a global power-down. The line-side outputs and the transmit system outputs are released to high impedance. The transmit system inputs are masked. The receive system outputs either float or are driven low, as one configuration input selects.

Recovery needs a run of consecutive good periods. When that run is complete, the block issues a device reset pulse of fixed length. The loss flag and the power-down end together with that pulse.

Top module: `refclk_loss_supervisor`

## Requirements
- R1: After reset, `ref_lost_o` and `dev_rst_o` are 0, `line_oe_o`, `rx_sys_oe_o` and `tx_sys_oe_o` are 1, `rx_sys_drive_low_o` is 0, and `tx_sys_data_o` equals `tx_sys_data_i`.
- R2: A complete period with H high monitor cycles and L low monitor cycles is good exactly when 100·H ≥ MIN_DUTY_PCT·(H+L) and 100·L ≥ MIN_DUTY_PCT·(H+L). Otherwise it is bad. The first period after reset or after a timeout is not judged.
- R3: Loss is declared once PERSIST_CYCLES monitor cycles have passed since a bad period with no good period in between. Any good period restarts this window.
- R4: If no rising edge of the reference is seen for MAX_PERIOD monitor cycles, that counts as a bad period. A stopped reference is therefore declared lost.
- R5: While lost, `line_oe_o` and `tx_sys_oe_o` are 0.
- R6: While lost, if `cfg_rx_low_i` is 1, then `rx_sys_oe_o` is 1 and `rx_sys_drive_low_o` is 1. If `cfg_rx_low_i` is 0, both are 0.
- R7: While lost, `tx_sys_data_o` is all zeros whatever `tx_sys_data_i` carries. Otherwise it follows `tx_sys_data_i`.
- R8: While lost, a reset pulse is issued only after RECOVER_PERIODS consecutive good periods. A bad period restarts the run. `dev_rst_o` then stays high for exactly RST_PULSE_LEN monitor cycles.
- R9: `ref_lost_o` falls on the same cycle as `dev_rst_o`. After that, all outputs return to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_mon_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk_i | input | 1 | Master reference clock under supervision, asynchronous |
| cfg_rx_low_i | input | 1 | 1: receive system outputs driven low in power-down; 0: high impedance |
| tx_sys_data_i | input | TXD_W | Transmit system interface inputs |
| ref_lost_o | output | 1 | Reference clock declared lost |
| line_oe_o | output | 1 | Line-interface output enable |
| rx_sys_oe_o | output | 1 | Receive system interface output enable |
| rx_sys_drive_low_o | output | 1 | Receive system outputs forced low |
| tx_sys_oe_o | output | 1 | Transmit system interface output enable |
| tx_sys_data_o | output | TXD_W | Transmit system inputs after power-down masking |
| dev_rst_o | output | 1 | Automatic device reset pulse on recovery |

## Verification
The hardest state to reach from the ports is a loss that does not recover, because the recovery run has been broken part way through. To reach it, the stimulus first stops the reference until it times out. It then feeds three good periods followed by one bad period, over and over, and checks that no reset pulse appears and that the loss flag holds. A steady good clock then completes the run, and the bench measures the pulse length and the cycle on which the loss flag falls. The duty-cycle rule is swept over every high time for two period lengths, so both 30% boundaries are covered.

// File: rtl/refclk_sup_pkg.sv
package refclk_sup_pkg;

  typedef enum logic [1:0] {
    SUP_WATCH = 2'd0,
    SUP_LOST  = 2'd1,
    SUP_RESET = 2'd2
  } sup_state_e;

endpackage

// File: rtl/refclk_edge_sync.sv
module refclk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sh_q;
  logic [SYNC_STAGES-1:0] sh_d;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign sh_d[s] = ref_i;
      end else begin : g_next
        assign sh_d[s] = sh_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o  = sh_q[SYNC_STAGES-1];
  assign rise_o = sh_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/refclk_period_meter.sv
module refclk_period_meter #(
  parameter int MAX_PERIOD   = 256,
  parameter int MIN_DUTY_PCT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  output logic good_o,
  output logic bad_o
);

  localparam int CNT_W = $clog2(MAX_PERIOD + 1);
  localparam int MW    = CNT_W + 8;

  logic [CNT_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic             primed_q, primed_d;
  logic             good_q, good_d, bad_q, bad_d;
  logic [CNT_W:0]   tot;
  logic             timeout;
  logic [MW-1:0]    hi_x, lo_x, tot_x;
  logic             duty_ok;

  assign tot     = {1'b0, hi_q} + {1'b0, lo_q};
  assign timeout = ~rise_i && (tot == (CNT_W+1)'(MAX_PERIOD - 1));

  assign hi_x    = MW'(hi_q) * MW'(100);
  assign lo_x    = MW'(lo_q) * MW'(100);
  assign tot_x   = MW'(tot) * MW'(MIN_DUTY_PCT);
  assign duty_ok = (tot != '0) && (hi_x >= tot_x) && (lo_x >= tot_x);

  always_comb begin
    hi_d     = hi_q;
    lo_d     = lo_q;
    primed_d = primed_q;
    good_d   = 1'b0;
    bad_d    = 1'b0;
    if (rise_i) begin
      if (primed_q) begin
        good_d = duty_ok;
        bad_d  = ~duty_ok;
      end
      primed_d = 1'b1;
      hi_d     = CNT_W'(1);
      lo_d     = '0;
    end else if (timeout) begin
      bad_d    = 1'b1;
      primed_d = 1'b0;
      hi_d     = '0;
      lo_d     = '0;
    end else if (lvl_i) begin
      hi_d = hi_q + CNT_W'(1);
    end else begin
      lo_d = lo_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_q     <= '0;
      primed_q <= 1'b0;
      good_q   <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      hi_q     <= hi_d;
      lo_q     <= lo_d;
      primed_q <= primed_d;
      good_q   <= good_d;
      bad_q    <= bad_d;
    end
  end

  assign good_o = good_q;
  assign bad_o  = bad_q;

  // R2: one verdict at most per cycle
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({good_o, bad_o}));

  // R4: the period counters never run past the timeout limit
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tot < (CNT_W+1)'(MAX_PERIOD));

endmodule

// File: rtl/refclk_loss_fsm.sv
module refclk_loss_fsm
  import refclk_sup_pkg::*;
#(
  parameter int PERSIST_CYCLES  = 1250,
  parameter int RECOVER_PERIODS = 8,
  parameter int RST_PULSE_LEN   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good_i,
  input  logic bad_i,
  output logic lost_o,
  output logic dev_rst_o
);

  localparam int PW = $clog2(PERSIST_CYCLES + 1);
  localparam int RW = $clog2(RECOVER_PERIODS + 1);
  localparam int LW = $clog2(RST_PULSE_LEN + 1);

  sup_state_e    st_q, st_d;
  logic          pend_q, pend_d;
  logic [PW-1:0] pers_q, pers_d;
  logic [RW-1:0] ok_q, ok_d;
  logic [LW-1:0] pul_q, pul_d;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    pers_d = pers_q;
    ok_d   = ok_q;
    pul_d  = pul_q;
    unique case (st_q)
      SUP_WATCH: begin
        if (good_i) begin
          pend_d = 1'b0;
          pers_d = '0;
        end else if (pend_q || bad_i) begin
          pend_d = 1'b1;
          if (pers_q == PW'(PERSIST_CYCLES - 1)) begin
            st_d = SUP_LOST;
            ok_d = '0;
          end else begin
            pers_d = pers_q + PW'(1);
          end
        end
      end
      SUP_LOST: begin
        if (bad_i) begin
          ok_d = '0;
        end else if (good_i) begin
          if (ok_q == RW'(RECOVER_PERIODS - 1)) begin
            st_d  = SUP_RESET;
            pul_d = '0;
          end else begin
            ok_d = ok_q + RW'(1);
          end
        end
      end
      SUP_RESET: begin
        if (pul_q == LW'(RST_PULSE_LEN - 1)) begin
          st_d   = SUP_WATCH;
          pend_d = 1'b0;
          pers_d = '0;
          ok_d   = '0;
        end else begin
          pul_d = pul_q + LW'(1);
        end
      end
      default: st_d = SUP_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SUP_WATCH;
      pend_q <= 1'b0;
      pers_q <= '0;
      ok_q   <= '0;
      pul_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      pers_q <= pers_d;
      ok_q   <= ok_d;
      pul_q  <= pul_d;
    end
  end

  assign lost_o    = (st_q != SUP_WATCH);
  assign dev_rst_o = (st_q == SUP_RESET);

  // R3: loss is only entered with a bad verdict pending
  p_loss_needs_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_o) |-> $past(pend_q));

  // R8: reset pulse starts only after a good period completed the run
  p_pulse_after_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_o) |-> $past(good_i));

endmodule

// File: rtl/refclk_loss_supervisor.sv
module refclk_loss_supervisor #(
  parameter int SYNC_STAGES     = 2,
  parameter int MAX_PERIOD      = 256,
  parameter int MIN_DUTY_PCT    = 30,
  parameter int PERSIST_CYCLES  = 1250,
  parameter int RECOVER_PERIODS = 8,
  parameter int RST_PULSE_LEN   = 16,
  parameter int TXD_W           = 8
) (
  input  logic             clk_mon,
  input  logic             rst_mon_n,
  input  logic             ref_clk_i,
  input  logic             cfg_rx_low_i,
  input  logic [TXD_W-1:0] tx_sys_data_i,
  output logic             ref_lost_o,
  output logic             line_oe_o,
  output logic             rx_sys_oe_o,
  output logic             rx_sys_drive_low_o,
  output logic             tx_sys_oe_o,
  output logic [TXD_W-1:0] tx_sys_data_o,
  output logic             dev_rst_o
);

  localparam int LW = $clog2(RST_PULSE_LEN + 1) + 1;

  logic [1:0] rst_sh_q;
  logic       rst_n;
  logic       lvl, rise, per_good, per_bad, lost, drst;

  always_ff @(posedge clk_mon or negedge rst_mon_n) begin
    if (!rst_mon_n) rst_sh_q <= 2'b00;
    else            rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n = rst_sh_q[1];

  refclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_mon), .rst_n(rst_n), .ref_i(ref_clk_i),
    .lvl_o(lvl), .rise_o(rise)
  );

  refclk_period_meter #(.MAX_PERIOD(MAX_PERIOD), .MIN_DUTY_PCT(MIN_DUTY_PCT)) u_meter (
    .clk(clk_mon), .rst_n(rst_n), .lvl_i(lvl), .rise_i(rise),
    .good_o(per_good), .bad_o(per_bad)
  );

  refclk_loss_fsm #(
    .PERSIST_CYCLES(PERSIST_CYCLES),
    .RECOVER_PERIODS(RECOVER_PERIODS),
    .RST_PULSE_LEN(RST_PULSE_LEN)
  ) u_fsm (
    .clk(clk_mon), .rst_n(rst_n), .good_i(per_good), .bad_i(per_bad),
    .lost_o(lost), .dev_rst_o(drst)
  );

  assign ref_lost_o         = lost;
  assign dev_rst_o          = drst;
  assign line_oe_o          = ~lost;
  assign tx_sys_oe_o        = ~lost;
  assign rx_sys_oe_o        = ~lost | cfg_rx_low_i;
  assign rx_sys_drive_low_o = lost & cfg_rx_low_i;
  assign tx_sys_data_o      = lost ? '0 : tx_sys_data_i;

  // checker-side run length of the reset pulse
  logic [LW-1:0] chk_run_q;
  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n)         chk_run_q <= '0;
    else if (dev_rst_o) chk_run_q <= chk_run_q + LW'(1);
    else                chk_run_q <= '0;
  end

  // R5: line and transmit outputs float while lost
  p_line_hiz_r5: assert property (@(posedge clk_mon) disable iff (!rst_n)
    ref_lost_o |-> (!line_oe_o && !tx_sys_oe_o));

  // R6: receive side follows the configured power-down mode
  p_rx_mode_r6: assert property (@(posedge clk_mon) disable iff (!rst_n)
    ref_lost_o |-> (rx_sys_oe_o == cfg_rx_low_i) && (rx_sys_drive_low_o == cfg_rx_low_i));

  // R7: transmit inputs masked during power-down
  p_tx_masked_r7: assert property (@(posedge clk_mon) disable iff (!rst_n)
    ref_lost_o |-> (tx_sys_data_o == '0));

  // R8: pulse has exactly the configured length
  p_pulse_len_r8: assert property (@(posedge clk_mon) disable iff (!rst_n)
    $fell(dev_rst_o) |-> (chk_run_q == LW'(RST_PULSE_LEN)));

  // R9: loss flag clears together with the end of the pulse
  p_clear_with_pulse_r9: assert property (@(posedge clk_mon) disable iff (!rst_n)
    $fell(dev_rst_o) |-> !ref_lost_o);

endmodule

// File: tb/refclk_loss_supervisor_tb.sv
module refclk_loss_supervisor_tb_top;

  localparam int MAXP = 32;
  localparam int PCT  = 30;
  localparam int PERS = 64;
  localparam int RECV = 4;
  localparam int PLEN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refc = 1'b0;
  logic       cfg_low = 1'b0;
  logic [7:0] txd_in = 8'h00;
  logic       lost, line_oe, rx_oe, rx_low, tx_oe, drst;
  logic [7:0] txd_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  int  run_len = 0, last_len = 0, pulses = 0;
  bit  prev_rst = 1'b0, lost_at_fall = 1'b1;

  always #4 clk = ~clk;

  refclk_loss_supervisor #(
    .SYNC_STAGES(2), .MAX_PERIOD(MAXP), .MIN_DUTY_PCT(PCT),
    .PERSIST_CYCLES(PERS), .RECOVER_PERIODS(RECV), .RST_PULSE_LEN(PLEN), .TXD_W(8)
  ) dut_i (
    .clk_mon(clk), .rst_mon_n(rst_n), .ref_clk_i(refc), .cfg_rx_low_i(cfg_low),
    .tx_sys_data_i(txd_in), .ref_lost_o(lost), .line_oe_o(line_oe),
    .rx_sys_oe_o(rx_oe), .rx_sys_drive_low_o(rx_low), .tx_sys_oe_o(tx_oe),
    .tx_sys_data_o(txd_out), .dev_rst_o(drst)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (drst) run_len = run_len + 1;
    else if (prev_rst) begin
      last_len     = run_len;
      run_len      = 0;
      lost_at_fall = lost;
      pulses       = pulses + 1;
    end
    prev_rst = drst;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    refc  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic periods(input int h, input int l, input int n);
    for (int k = 0; k < n; k++) begin
      refc = 1'b1;
      repeat (h) @(negedge clk);
      refc = 1'b0;
      repeat (l) @(negedge clk);
    end
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    txd_in = 8'hA5;
    do_reset();
    check(lost == 1'b0 && drst == 1'b0, "R1 flags", {lost, drst}, 0);
    check(line_oe && rx_oe && tx_oe && !rx_low, "R1 enables",
          {line_oe, rx_oe, tx_oe, rx_low}, 4'b1110);
    check(txd_out == 8'hA5, "R1 tx pass", txd_out, 8'hA5);

    // R2: sweep every high time for two period lengths
    for (int p = 10; p <= 20; p += 10) begin
      for (int h = 1; h < p; h++) begin
        bit bad_exp;
        bad_exp = !((100 * h >= PCT * p) && (100 * (p - h) >= PCT * p));
        do_reset();
        periods(h, p - h, 300 / p * 2);
        check(lost == bad_exp, $sformatf("R2 duty h=%0d p=%0d", h, p), lost, bad_exp);
      end
    end

    // R3: loss only after the persistence window
    do_reset();
    periods(5, 5, 10);
    periods(1, 9, 5);
    check(lost == 1'b0, "R3 not early", lost, 0);
    periods(1, 9, 6);
    check(lost == 1'b1, "R3 declared", lost, 1);

    // R3: good periods inside the window keep restarting it
    do_reset();
    for (int k = 0; k < 12; k++) begin
      periods(1, 9, 2);
      periods(5, 5, 1);
    end
    check(lost == 1'b0, "R3 restart", lost, 0);

    // R4: stopped reference
    do_reset();
    periods(5, 5, 5);
    refc = 1'b0;
    repeat (150) @(negedge clk);
    check(lost == 1'b1, "R4 stopped", lost, 1);

    // R5, R6, R7 while lost
    cfg_low = 1'b0;
    txd_in  = 8'hFF;
    @(negedge clk);
    check(!line_oe && !tx_oe, "R5 hiz", {line_oe, tx_oe}, 0);
    check(!rx_oe && !rx_low, "R6 float", {rx_oe, rx_low}, 0);
    check(txd_out == 8'h00, "R7 masked", txd_out, 0);
    cfg_low = 1'b1;
    @(negedge clk);
    check(rx_oe && rx_low, "R6 drive low", {rx_oe, rx_low}, 3);

    // R8: broken recovery runs give no pulse
    pulses = 0;
    for (int k = 0; k < 8; k++) begin
      periods(5, 5, 3);
      periods(1, 9, 1);
    end
    check(pulses == 0 && drst == 1'b0, "R8 no pulse", pulses, 0);
    check(lost == 1'b1, "R8 stays lost", lost, 1);

    // R8, R9: full recovery
    periods(5, 5, 10);
    check(pulses == 1, "R8 one pulse", pulses, 1);
    check(last_len == PLEN, "R8 pulse length", last_len, PLEN);
    check(lost_at_fall == 1'b0, "R9 clear with pulse", lost_at_fall, 0);
    check(lost == 1'b0 && line_oe && tx_oe && !rx_low, "R9 outputs restored",
          {lost, line_oe, tx_oe, rx_low}, 4'b0110);
    check(txd_out == 8'hFF, "R9 tx pass", txd_out, 8'hFF);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule